// File: doc/BRIEF.md
# Link Training Supervisor with Speed-Change Stall Recovery

This block watches a PCI Express link while it trains and reports the outcome. A start pulse begins monitoring. The block then polls two 32-bit debug status words from the controller core. It declares the link up when the "link up" flag is set and the "in training" flag is clear. On every poll that does not find the link up, it reads a receiver status register through a 16-bit PHY register port.

If the training state machine sits in Recovery.RcvrLock while the receiver reports no valid data, the speed change has stalled. In that case the block forces two receiver override enables on in a PHY register, using read-modify-write. It holds them on for a fixed number of timebase ticks and then clears them, again by read-modify-write.

A poll budget limits the wait. After a set number of unsuccessful polls, a sticky failure flag is raised. The timebase tick is expected at 1 µs, so the defaults give a 10 µs poll interval, a 3 ms override hold and a budget of 4000 polls. The PHY access engine sits behind a simple request/acknowledge port.

Top module: `lum_link_monitor`

## Requirements
- R1: After reset, `link_up`, `link_fail` and `phy_req` are all 0.
- R2: A poll finds the link up when bit 4 of `dbg1` is 1 and bit 29 of `dbg1` is 0. This sets `link_up`, and no further PHY access is made for that run.
- R3: When bit 4 and bit 29 of `dbg1` are both 1, the link is not up and polling continues.
- R4: Every poll that does not find the link up issues one PHY read of address 0x100D. Consecutive polls are separated by at least POLL_TICKS ticks.
- R5: A stall is bits 5:0 of `dbg0` equal to 0x0D together with bit 0 of the 0x100D read data equal to 0. Bits 31:6 of `dbg0` are ignored.
- R6: On a stall, the block reads PHY address 0x1005 and writes back the read value with bits 5 and 3 set. It waits at least HOLD_TICKS ticks, reads 0x1005 again, and writes back that value with bits 5 and 3 cleared. All other bits keep the value that was read.
- R7: No PHY write is made when bit 0 of the 0x100D data is 1, or when bits 5:0 of `dbg0` differ from 0x0D.
- R8: After POLL_LIMIT unsuccessful polls, `link_fail` is set, and exactly POLL_LIMIT reads of 0x100D have been made. Recovery holds do not count against the budget.
- R9: `link_up` and `link_fail` stay set until the next `start`. A `start` clears both flags and the poll budget.
- R10: Once `phy_req` is raised, it and `phy_we`, `phy_addr` and `phy_wdata` stay stable until the cycle in which `phy_ack` is 1. It is then dropped for at least one cycle.
- R11: `link_up` and `link_fail` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a monitoring run (taken when not busy) |
| tick | input | 1 | Timebase tick, one cycle wide |
| dbg0 | input | 32 | Debug word 0; bits 5:0 hold the training state |
| dbg1 | input | 32 | Debug word 1; bit 4 link up, bit 29 in training |
| phy_req | output | 1 | PHY access request |
| phy_we | output | 1 | 1 for write, 0 for read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | One-cycle completion from the PHY engine |
| phy_rdata | input | 16 | PHY read data, valid with `phy_ack` |
| link_up | output | 1 | Sticky link-up result |
| link_fail | output | 1 | Sticky budget-exhausted result |

## Verification
The assertions assume that the PHY engine raises `phy_ack` only while `phy_req` is high, and for a single cycle. They also assume that `start` arrives only when no run is in progress. The bench's PHY stub answers each request once, after a random latency of one to three cycles, and then lowers `phy_ack`. It issues `start` only after a run has finished or before the first run. Ticks arrive at random on about three cycles in four. The debug words change only at cycle boundaries and are chosen to drive the directed and random cases.

// File: rtl/lum_pkg.sv
package lum_pkg;

    localparam logic [15:0] RXSTAT_ADDR = 16'h100D;
    localparam logic [15:0] RXOVR_ADDR  = 16'h1005;
    localparam logic [15:0] OVR_MASK    = 16'h0028;   // bit 5 data enable, bit 3 PLL enable
    localparam logic [5:0]  STALL_STATE = 6'h0D;
    localparam int          UP_BIT      = 4;
    localparam int          TRAIN_BIT   = 29;

    typedef enum logic [3:0] {
        S_IDLE, S_CHECK, S_RXV_ISS, S_RXV_WAIT,
        S_SRD_ISS, S_SRD_WAIT, S_SWR_ISS, S_SWR_WAIT,
        S_HOLD, S_CRD_ISS, S_CRD_WAIT, S_CWR_ISS, S_CWR_WAIT,
        S_COUNT, S_WAIT, S_DONE
    } mon_state_t;

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [15:0] wdata;
    } phy_cmd_t;

    function automatic logic link_is_up(input logic [31:0] d1);
        return d1[UP_BIT] && !d1[TRAIN_BIT];
    endfunction

    function automatic logic stall_seen(input logic [31:0] d0, input logic rx_valid);
        return (d0[5:0] == STALL_STATE) && !rx_valid;
    endfunction

    function automatic phy_cmd_t mk_read(input logic [15:0] a);
        phy_cmd_t c;
        c.we    = 1'b0;
        c.addr  = a;
        c.wdata = '0;
        return c;
    endfunction

    function automatic phy_cmd_t mk_write(input logic [15:0] a, input logic [15:0] d);
        phy_cmd_t c;
        c.we    = 1'b1;
        c.addr  = a;
        c.wdata = d;
        return c;
    endfunction

endpackage

// File: rtl/lum_tick_timer.sv
module lum_tick_timer #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             tick,
    output logic             expired
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/lum_poll_budget.sv
module lum_poll_budget #(
    parameter int LIMIT = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

    logic [CW-1:0] used_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            used_q <= '0;
        end else if (inc) begin
            used_q <= used_q + 1'b1;
        end
    end

    // this poll is the final one the budget allows
    assign last = (used_q == LAST_VAL);
endmodule

// File: rtl/lum_phy_port.sv
module lum_phy_port
    import lum_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        issue,
    input  phy_cmd_t    cmd,
    input  logic        ack,
    input  logic [15:0] rdata,
    output logic        req,
    output phy_cmd_t    cmd_q,
    output logic        done,
    output logic [15:0] rd_q
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            cmd_q <= '0;
            rd_q  <= '0;
        end else begin
            if (issue) begin
                req_q <= 1'b1;
                cmd_q <= cmd;
            end else if (req_q && ack) begin
                req_q <= 1'b0;
            end
            if (req_q && ack) begin
                rd_q <= rdata;
            end
        end
    end

    assign req  = req_q;
    assign done = req_q && ack;
endmodule

// File: rtl/lum_link_monitor.sv
module lum_link_monitor
    import lum_pkg::*;
#(
    parameter int POLL_TICKS = 10,
    parameter int HOLD_TICKS = 3000,
    parameter int POLL_LIMIT = 4000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        tick,
    input  logic [31:0] dbg0,
    input  logic [31:0] dbg1,
    output logic        phy_req,
    output logic        phy_we,
    output logic [15:0] phy_addr,
    output logic [15:0] phy_wdata,
    input  logic        phy_ack,
    input  logic [15:0] phy_rdata,
    output logic        link_up,
    output logic        link_fail
);
    localparam int TMR_MAX = (HOLD_TICKS > POLL_TICKS) ? HOLD_TICKS : POLL_TICKS;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] POLL_LOAD = TMR_W'(POLL_TICKS);
    localparam logic [TMR_W-1:0] HOLD_LOAD = TMR_W'(HOLD_TICKS);

    mon_state_t       st_q, st_d;
    logic             issue;
    phy_cmd_t         cmd, cmd_q;
    logic             done;
    logic [15:0]      rd_q;
    logic             tmr_load, tmr_exp;
    logic [TMR_W-1:0] tmr_val;
    logic             bud_clr, bud_inc, bud_last;
    logic             set_up, set_fail, clr_flags;
    logic             up_q, fail_q;

    lum_tick_timer #(.WIDTH(TMR_W)) tmr_i (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .tick(tick), .expired(tmr_exp)
    );

    lum_poll_budget #(.LIMIT(POLL_LIMIT)) bud_i (
        .clk(clk), .rst(rst), .clr(bud_clr), .inc(bud_inc), .last(bud_last)
    );

    lum_phy_port port_i (
        .clk(clk), .rst(rst), .issue(issue), .cmd(cmd), .ack(phy_ack),
        .rdata(phy_rdata), .req(phy_req), .cmd_q(cmd_q), .done(done), .rd_q(rd_q)
    );

    always_comb begin
        st_d      = st_q;
        issue     = 1'b0;
        cmd       = '0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        bud_clr   = 1'b0;
        bud_inc   = 1'b0;
        set_up    = 1'b0;
        set_fail  = 1'b0;
        clr_flags = 1'b0;
        unique case (st_q)
            S_IDLE, S_DONE: begin
                if (start) begin
                    clr_flags = 1'b1;
                    bud_clr   = 1'b1;
                    st_d      = S_CHECK;
                end
            end
            S_CHECK: begin
                if (link_is_up(dbg1)) begin
                    set_up = 1'b1;
                    st_d   = S_DONE;
                end else begin
                    st_d = S_RXV_ISS;
                end
            end
            S_RXV_ISS: begin
                issue = 1'b1;
                cmd   = mk_read(RXSTAT_ADDR);
                st_d  = S_RXV_WAIT;
            end
            S_RXV_WAIT: begin
                if (done) begin
                    st_d = stall_seen(dbg0, phy_rdata[0]) ? S_SRD_ISS : S_COUNT;
                end
            end
            S_SRD_ISS: begin
                issue = 1'b1;
                cmd   = mk_read(RXOVR_ADDR);
                st_d  = S_SRD_WAIT;
            end
            S_SRD_WAIT: if (done) st_d = S_SWR_ISS;
            S_SWR_ISS: begin
                issue = 1'b1;
                cmd   = mk_write(RXOVR_ADDR, rd_q | OVR_MASK);
                st_d  = S_SWR_WAIT;
            end
            S_SWR_WAIT: begin
                if (done) begin
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LOAD;
                    st_d     = S_HOLD;
                end
            end
            S_HOLD: if (tmr_exp) st_d = S_CRD_ISS;
            S_CRD_ISS: begin
                issue = 1'b1;
                cmd   = mk_read(RXOVR_ADDR);
                st_d  = S_CRD_WAIT;
            end
            S_CRD_WAIT: if (done) st_d = S_CWR_ISS;
            S_CWR_ISS: begin
                issue = 1'b1;
                cmd   = mk_write(RXOVR_ADDR, rd_q & ~OVR_MASK);
                st_d  = S_CWR_WAIT;
            end
            S_CWR_WAIT: if (done) st_d = S_COUNT;
            S_COUNT: begin
                if (bud_last) begin
                    set_fail = 1'b1;
                    st_d     = S_DONE;
                end else begin
                    bud_inc  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = POLL_LOAD;
                    st_d     = S_WAIT;
                end
            end
            S_WAIT: if (tmr_exp) st_d = S_CHECK;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            up_q   <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (clr_flags) begin
                up_q   <= 1'b0;
                fail_q <= 1'b0;
            end else begin
                if (set_up)   up_q   <= 1'b1;
                if (set_fail) fail_q <= 1'b1;
            end
        end
    end

    assign phy_we    = cmd_q.we;
    assign phy_addr  = cmd_q.addr;
    assign phy_wdata = cmd_q.wdata;
    assign link_up   = up_q;
    assign link_fail = fail_q;
endmodule

// File: rtl/lum_link_monitor_chk.sv
module lum_link_monitor_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        phy_req,
    input logic        phy_ack,
    input logic        phy_we,
    input logic [15:0] phy_addr,
    input logic [15:0] phy_wdata,
    input logic        link_up,
    input logic        link_fail
);
    // R10: pending request holds its fields
    assert_req_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (phy_req && !phy_ack) |=> (phy_req && $stable(phy_we) && $stable(phy_addr) && $stable(phy_wdata)));

    // R10: request drops after completion
    assert_req_gap_R10: assert property (@(posedge clk) disable iff (rst)
        (phy_req && phy_ack) |=> !phy_req);

    // R11
    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(link_up && link_fail));

    // R9
    assert_up_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (link_up && !start) |=> link_up);

    assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (link_fail && !start) |=> link_fail);

    // R6/R7: only the override register is ever written
    assert_write_target_R6: assert property (@(posedge clk) disable iff (rst)
        (phy_req && phy_we) |-> (phy_addr == 16'h1005));

    // R2: no PHY traffic once the link is reported up
    assert_quiet_after_up_R2: assert property (@(posedge clk) disable iff (rst)
        (link_up && $past(link_up)) |-> !$rose(phy_req));
endmodule

bind lum_link_monitor lum_link_monitor_chk chk_i (
    .clk(clk), .rst(rst), .start(start), .phy_req(phy_req), .phy_ack(phy_ack),
    .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .link_up(link_up), .link_fail(link_fail)
);

// File: tb/lum_link_monitor_tb.sv
module lum_link_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PT = 4;
    localparam int HT = 24;
    localparam int PL = 10;
    localparam logic [15:0] MASK = 16'h0028;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        tick = 1'b0;
    logic [31:0] dbg0 = '0;
    logic [31:0] dbg1 = '0;
    logic        phy_req, phy_we;
    logic [15:0] phy_addr, phy_wdata;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_rdata = '0;
    logic        link_up, link_fail;

    int checks = 0;
    int errors = 0;

    // PHY stub state
    logic [15:0] reg_rx = '0;
    logic [15:0] reg_ovr = '0;
    int n_rx = 0, n_wr = 0, proto_err = 0, wdata_err = 0;
    int since_rx = 0, min_iv = 1 << 30, max_iv = 0;
    bit rec_between = 0;
    int hold_ticks = 0, last_hold = 0;
    bit pend = 0;
    int lat = 0;
    logic        p_we;
    logic [15:0] p_addr, p_wdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lum_link_monitor #(.POLL_TICKS(PT), .HOLD_TICKS(HT), .POLL_LIMIT(PL)) dut_i (
        .clk(clk), .rst(rst), .start(start), .tick(tick), .dbg0(dbg0), .dbg1(dbg1),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata), .link_up(link_up), .link_fail(link_fail)
    );

    function automatic bit exp_up(input logic [31:0] d1);
        return d1[4] && !d1[29];
    endfunction

    function automatic bit exp_stall(input logic [31:0] d0, input logic [15:0] rx);
        return (d0[5:0] == 6'h0D) && (rx[0] == 1'b0);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // stub, tick source and monitors, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            tick = (($urandom % 4) != 0);
            if (((reg_ovr & MASK) == MASK) && tick) hold_ticks++;
            if (tick) since_rx++;
            if (phy_ack) begin
                phy_ack = 1'b0;
            end else if (phy_req) begin
                if (!pend) begin
                    pend = 1; lat = $urandom % 3;
                    p_we = phy_we; p_addr = phy_addr; p_wdata = phy_wdata;
                end else if (p_we !== phy_we || p_addr !== phy_addr || p_wdata !== phy_wdata) begin
                    proto_err++;
                end
                if (lat == 0) begin
                    pend = 0;
                    phy_ack = 1'b1;
                    if (phy_we) begin
                        n_wr++;
                        rec_between = 1;
                        if (n_wr % 2 == 1) begin
                            if (phy_wdata !== (reg_ovr | MASK)) wdata_err++;
                            hold_ticks = 0;
                        end else begin
                            if (phy_wdata !== (reg_ovr & ~MASK)) wdata_err++;
                            last_hold = hold_ticks;
                        end
                        if (phy_addr == 16'h1005) reg_ovr = phy_wdata;
                        else proto_err++;
                    end else begin
                        phy_rdata = (phy_addr == 16'h100D) ? reg_rx :
                                    (phy_addr == 16'h1005) ? reg_ovr : 16'hDEAD;
                        if (phy_addr == 16'h100D) begin
                            n_rx++;
                            if (n_rx > 1 && !rec_between) begin
                                if (since_rx < min_iv) min_iv = since_rx;
                                if (since_rx > max_iv) max_iv = since_rx;
                            end
                            since_rx = 0;
                            rec_between = 0;
                        end
                    end
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic clear_stats();
        n_rx = 0; n_wr = 0; min_iv = 1 << 30; max_iv = 0; rec_between = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_result();
        while (!(link_up || link_fail)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_reads(input int n);
        while (n_rx < n) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(link_up == 0 && link_fail == 0, "R1 flags after reset", {link_up, link_fail}, 0);
        check(phy_req == 0, "R1 no request after reset", phy_req, 0);

        // R2: link already up at start, no PHY reads
        clear_stats(); dbg1 = 32'h0000_0010;
        pulse_start(); wait_result();
        check(link_up == exp_up(dbg1), "R2 immediate link up", link_up, 1);
        check(n_rx == 0, "R2 no PHY access when up", n_rx, 0);

        // R9 sticky after status drops
        dbg1 = 32'h0; repeat (40) @(negedge clk);
        check(link_up == 1, "R9 link_up sticky", link_up, 1);
        check(link_fail == 0, "R11 exclusive flags", link_fail, 0);

        // R3: up bit with training bit; R4 interval
        clear_stats(); dbg1 = 32'h2000_0010; dbg0 = 32'h11; reg_rx = 16'h0001;
        pulse_start();
        check(link_up == 0, "R9 start clears link_up", link_up, 0);
        wait_reads(4); @(negedge clk);
        check(link_up == exp_up(dbg1), "R3 training bit blocks link up", link_up, 0);
        dbg1 = 32'h0000_0010;
        wait_result();
        check(link_up == 1, "R2 link up after training clears", link_up, 1);
        check(min_iv >= PT, "R4 minimum poll spacing", min_iv, PT);
        check(max_iv <= PT + 12, "R4 maximum poll spacing", max_iv, PT + 12);
        check(n_wr == 0, "R7 no writes without stall", n_wr, 0);

        // R8: exhaust budget without stall
        clear_stats(); dbg1 = 32'h0; dbg0 = 32'h0000_0003; reg_rx = 16'h0000;
        pulse_start(); wait_result();
        check(link_fail == 1, "R8 link_fail after budget", link_fail, 1);
        check(n_rx == PL, "R8 read count equals budget", n_rx, PL);
        check(link_up == 0, "R11 no link_up with fail", link_up, 0);
        check(n_wr == 0, "R7 state 0x03 gives no recovery", n_wr, 0);

        // R7: state 0x0D but receiver valid
        clear_stats(); dbg0 = 32'h0000_000D; reg_rx = 16'hFFFF;
        pulse_start();
        check(link_fail == 0, "R9 start clears link_fail", link_fail, 0);
        wait_result();
        check(n_wr == 0, "R7 valid receiver suppresses recovery", n_wr, 0);

        // R5/R6: one stall with upper debug bits set, then link up
        clear_stats(); dbg0 = 32'hABCD_004D; reg_rx = 16'hFFFE; reg_ovr = 16'h1234;
        pulse_start();
        while (n_wr < 2) @(negedge clk);
        dbg1 = 32'h0000_0010;
        wait_result();
        check(n_wr == 2 * (exp_stall(dbg0, reg_rx) ? 1 : 0), "R5 stall detected, upper bits ignored", n_wr, 2);
        check(reg_ovr == 16'h1214, "R6 override bits cleared, others kept", reg_ovr, 16'h1214);
        check(wdata_err == 0, "R6 read-modify-write data", wdata_err, 0);
        check(last_hold >= HT && last_hold <= HT + 12, "R6 hold duration", last_hold, HT);
        check(link_up == 1, "R2 link up after recovery", link_up, 1);

        // R8: persistent stall, holds not charged to budget
        clear_stats(); dbg1 = 32'h0; reg_ovr = 16'h00F0;
        pulse_start(); wait_result();
        check(link_fail == 1, "R8 fail under persistent stall", link_fail, 1);
        check(n_rx == PL, "R8 polls exclude hold time", n_rx, PL);
        check(n_wr == 2 * PL, "R6 one recovery per poll", n_wr, 2 * PL);

        // random trials
        for (int t = 0; t < 8; t++) begin
            int k, exp_reads;
            bit st;
            clear_stats();
            dbg0 = (($urandom % 2) == 0) ? {$urandom, 6'h0D} : 32'($urandom);
            reg_rx = 16'($urandom);
            reg_ovr = 16'($urandom);
            k = $urandom % (PL + 3);
            dbg1 = (k == 0) ? 32'h0000_0010 : 32'h0;
            st = exp_stall(dbg0, reg_rx);
            pulse_start();
            if (k > 0 && k < PL) begin
                wait_reads(k);
                dbg1 = 32'h0000_0010;
            end
            wait_result();
            exp_reads = (k < PL) ? k : PL;
            check(n_rx == exp_reads, "R4 random poll count", n_rx, exp_reads);
            check(n_wr == (st ? 2 * exp_reads : 0), "R5 random recovery count", n_wr, st ? 2 * exp_reads : 0);
            check(link_up == (k < PL) && link_fail == (k >= PL), "R8 random outcome",
                  {link_up, link_fail}, (k < PL) ? 2 : 1);
            dbg1 = 32'h0;
        end

        check(proto_err == 0, "R10 request fields stable", proto_err, 0);
        check(wdata_err == 0, "R6 all write data", wdata_err, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule